// File: doc/BRIEF.md
# Partitioned Shared FIFO Buffer

A single shared buffer of 4096 words of 32 bits is split at run time into four circular FIFOs: a transmit data queue, a transmit status queue, a receive data queue and a receive status queue. One size field gives the transmit share in units of 256 words. The block derives each region's base, depth and full limit from that field. The transmit status queue is always 128 words, and the transmit data queue gets the rest of the transmit share. The receive share is whatever the transmit share leaves. One sixteenth of it goes to receive status, and the remainder goes to receive data.

The buffer is a plain dual-port RAM, so it has one push port and one pop port. A select field on each port picks the FIFO. Read data comes back one cycle after an accepted pop. A one-cycle soft-reset strobe empties every FIFO and clears both error flags. On that strobe only, the block loads a new size field if the value lies in the legal range. A dropped push or pop raises a sticky error flag for the transmit side or for the receive side.

Top module: `fifo_part_buf`

## Requirements
- R1: With size field S, the depths in words are: transmit data S*256-128, transmit status 128, receive status (4096-S*256)/16, and receive data equal to the receive share minus the receive status depth. full_o of a FIFO is 1 exactly when its count reaches its limit. Select and index encoding: 0 transmit data, 1 transmit status, 2 receive data, 3 receive status.
- R2: The receive data FIFO (index 2) reports full and refuses pushes once its count equals its depth minus 4.
- R3: A push to a full FIFO leaves its contents and count unchanged. It sets tx_err_o for index 0 or 1, or rx_err_o for index 2 or 3. Both flags stay set until a soft reset.
- R4: A pop from an empty FIFO is dropped. It gives no pop_valid_o and sets the error flag of its side.
- R5: Each FIFO returns its words in push order. pop_data_o and pop_valid_o appear in the cycle after the accepted pop.
- R6: A cycle with soft_rst_i high empties all four FIFOs and clears both error flags. It loads cfg_size_i when that value is within 2 to 14, and cur_size_o reports the partition in effect. A push or pop in the same cycle is ignored.
- R7: A soft reset with a reserved size value (0, 1 or 15) keeps the previous partition.
- R8: A change of cfg_size_i without a soft reset has no effect on the partition.
- R9: The FIFOs are independent. Traffic on one never changes another's count or data, and each FIFO's pointers wrap inside its own region.
- R10: After rst_ni is released, the partition is size 6, all FIFOs are empty and both error flags are clear.
- R11: A push and a pop in the same cycle both take effect, including on the same FIFO when it is neither full nor empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Self-clearing soft-reset strobe |
| cfg_size_i | input | 4 | Transmit share in 256-word units |
| push_i | input | 1 | Push request |
| push_sel_i | input | 2 | FIFO selected for the push |
| push_data_i | input | 32 | Push data |
| pop_i | input | 1 | Pop request |
| pop_sel_i | input | 2 | FIFO selected for the pop |
| pop_data_o | output | 32 | Popped word, one cycle after the pop |
| pop_valid_o | output | 1 | pop_data_o is valid |
| count_o | output | 4x13 | Occupancy per FIFO |
| full_o | output | 4 | Full per FIFO |
| empty_o | output | 4 | Empty per FIFO |
| tx_err_o | output | 1 | Sticky transmit-side drop flag |
| rx_err_o | output | 1 | Sticky receive-side drop flag |
| cur_size_o | output | 4 | Size field in effect |

## Verification
The assertions check four things on every cycle. A push to a full FIFO never changes its count. A pop from an empty FIFO never yields valid data. The error flags stay set until a soft reset, and a soft reset leaves every count at zero. The partition also never changes outside a soft reset and never holds a reserved value. The bench's scenarios show what the assertions cannot: the depth of each region for several size values, the early full point of the receive data FIFO, and the data order across pointer wraps. They compare every cycle against a queue-based reference model.

// File: rtl/fifo_part_pkg.sv
package fifo_part_pkg;
  localparam int NF    = 4;
  localparam int SEL_W = $clog2(NF);
  // index order is decoded by the error-side logic: 0,1 transmit; 2,3 receive
  typedef enum logic [SEL_W-1:0] {
    FID_TXD = 2'd0,
    FID_TXS = 2'd1,
    FID_RXD = 2'd2,
    FID_RXS = 2'd3
  } fid_e;
endpackage

// File: rtl/fifo_part_map.sv
module fifo_part_map
  import fifo_part_pkg::*;
#(
  parameter int TOTAL_WORDS = 4096,
  parameter int UNIT_WORDS  = 256,
  parameter int TXS_WORDS   = 128,
  parameter int RXS_DIV     = 16,
  parameter int RXD_MARGIN  = 4,
  parameter int SZ_W        = 4,
  localparam int AW = $clog2(TOTAL_WORDS),
  localparam int CW = AW + 1
) (
  input  logic [SZ_W-1:0]         size_i,
  output logic [NF-1:0][AW-1:0]   base_o,
  output logic [NF-1:0][CW-1:0]   depth_o,
  output logic [NF-1:0][CW-1:0]   lim_o
);
  logic [CW-1:0] tx_tot, txd, rx_tot, rxs, rxd;

  always_comb begin
    tx_tot = CW'(size_i) * CW'(UNIT_WORDS);
    txd    = tx_tot - CW'(TXS_WORDS);
    rx_tot = CW'(TOTAL_WORDS) - tx_tot;
    rxs    = rx_tot / CW'(RXS_DIV);
    rxd    = rx_tot - rxs;

    depth_o[FID_TXD] = txd;
    depth_o[FID_TXS] = CW'(TXS_WORDS);
    depth_o[FID_RXD] = rxd;
    depth_o[FID_RXS] = rxs;

    lim_o          = depth_o;
    lim_o[FID_RXD] = rxd - CW'(RXD_MARGIN);

    base_o[FID_TXD] = '0;
    base_o[FID_TXS] = AW'(txd);
    base_o[FID_RXD] = AW'(tx_tot);
    base_o[FID_RXS] = AW'(tx_tot + rxd);
  end
endmodule

// File: rtl/fifo_part_ctrl.sv
module fifo_part_ctrl #(
  parameter int AW = 12,
  localparam int CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [CW-1:0] depth_i,
  input  logic [CW-1:0] lim_i,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [AW-1:0] wptr_o,
  output logic [AW-1:0] rptr_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          push_ok_o,
  output logic          pop_ok_o
);
  logic [CW-1:0] last;

  assign last      = depth_i - CW'(1);
  assign full_o    = count_o >= lim_i;
  assign empty_o   = count_o == '0;
  assign push_ok_o = push_i & ~full_o;
  assign pop_ok_o  = pop_i & ~empty_o;

  // region-relative wrap at depth-1
  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p, input logic [CW-1:0] l);
    return ({1'b0, p} == l) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_o  <= '0;
      rptr_o  <= '0;
      count_o <= '0;
    end else if (clr_i) begin
      wptr_o  <= '0;
      rptr_o  <= '0;
      count_o <= '0;
    end else begin
      if (push_ok_o) wptr_o <= bump(wptr_o, last);
      if (pop_ok_o)  rptr_o <= bump(rptr_o, last);
      case ({push_ok_o, pop_ok_o})
        2'b10:   count_o <= count_o + CW'(1);
        2'b01:   count_o <= count_o - CW'(1);
        default: count_o <= count_o;
      endcase
    end
  end
endmodule

// File: rtl/fifo_part_ram.sv
module fifo_part_ram #(
  parameter int DW    = 32,
  parameter int WORDS = 4096,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[raddr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rvalid_o <= 1'b0;
    else         rvalid_o <= re_i;
  end
endmodule

// File: rtl/fifo_part_buf.sv
module fifo_part_buf
  import fifo_part_pkg::*;
#(
  parameter int DW          = 32,
  parameter int TOTAL_WORDS = 4096,
  parameter int UNIT_WORDS  = 256,
  parameter int TXS_WORDS   = 128,
  parameter int RXS_DIV     = 16,
  parameter int RXD_MARGIN  = 4,
  parameter int SZ_W        = 4,
  parameter int SZ_MIN      = 2,
  parameter int SZ_MAX      = 14,
  parameter int SZ_DEF      = 6,
  localparam int AW = $clog2(TOTAL_WORDS),
  localparam int CW = AW + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  soft_rst_i,
  input  logic [SZ_W-1:0]       cfg_size_i,
  input  logic                  push_i,
  input  logic [SEL_W-1:0]      push_sel_i,
  input  logic [DW-1:0]         push_data_i,
  input  logic                  pop_i,
  input  logic [SEL_W-1:0]      pop_sel_i,
  output logic [DW-1:0]         pop_data_o,
  output logic                  pop_valid_o,
  output logic [NF-1:0][CW-1:0] count_o,
  output logic [NF-1:0]         full_o,
  output logic [NF-1:0]         empty_o,
  output logic                  tx_err_o,
  output logic                  rx_err_o,
  output logic [SZ_W-1:0]       cur_size_o
);
  logic [SZ_W-1:0]       sz_q;
  logic                  sz_ok;
  logic [NF-1:0][AW-1:0] base, wptr, rptr;
  logic [NF-1:0][CW-1:0] depth, lim;
  logic [NF-1:0]         push_req, pop_req, push_ok, pop_ok, drop;

  assign sz_ok = (cfg_size_i >= SZ_W'(SZ_MIN)) && (cfg_size_i <= SZ_W'(SZ_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  sz_q <= SZ_W'(SZ_DEF);
    else if (soft_rst_i && sz_ok) sz_q <= cfg_size_i;
  end
  assign cur_size_o = sz_q;

  fifo_part_map #(
    .TOTAL_WORDS(TOTAL_WORDS), .UNIT_WORDS(UNIT_WORDS), .TXS_WORDS(TXS_WORDS),
    .RXS_DIV(RXS_DIV), .RXD_MARGIN(RXD_MARGIN), .SZ_W(SZ_W)
  ) u_map (
    .size_i(sz_q), .base_o(base), .depth_o(depth), .lim_o(lim)
  );

  for (genvar g = 0; g < NF; g++) begin : g_fifo
    assign push_req[g] = push_i & ~soft_rst_i & (push_sel_i == SEL_W'(g));
    assign pop_req[g]  = pop_i  & ~soft_rst_i & (pop_sel_i  == SEL_W'(g));
    assign drop[g]     = (push_req[g] & ~push_ok[g]) | (pop_req[g] & ~pop_ok[g]);

    fifo_part_ctrl #(.AW(AW)) u_ctrl (
      .clk_i, .rst_ni,
      .clr_i     (soft_rst_i),
      .depth_i   (depth[g]),
      .lim_i     (lim[g]),
      .push_i    (push_req[g]),
      .pop_i     (pop_req[g]),
      .wptr_o    (wptr[g]),
      .rptr_o    (rptr[g]),
      .count_o   (count_o[g]),
      .full_o    (full_o[g]),
      .empty_o   (empty_o[g]),
      .push_ok_o (push_ok[g]),
      .pop_ok_o  (pop_ok[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_err_o <= 1'b0;
      rx_err_o <= 1'b0;
    end else if (soft_rst_i) begin
      tx_err_o <= 1'b0;
      rx_err_o <= 1'b0;
    end else begin
      if (drop[FID_TXD] | drop[FID_TXS]) tx_err_o <= 1'b1;
      if (drop[FID_RXD] | drop[FID_RXS]) rx_err_o <= 1'b1;
    end
  end

  fifo_part_ram #(.DW(DW), .WORDS(TOTAL_WORDS)) u_ram (
    .clk_i, .rst_ni,
    .we_i     (|push_ok),
    .waddr_i  (base[push_sel_i] + wptr[push_sel_i]),
    .wdata_i  (push_data_i),
    .re_i     (|pop_ok),
    .raddr_i  (base[pop_sel_i] + rptr[pop_sel_i]),
    .rdata_o  (pop_data_o),
    .rvalid_o (pop_valid_o)
  );
endmodule

module fifo_part_chk
  import fifo_part_pkg::*;
#(
  parameter int CW     = 13,
  parameter int SZ_W   = 4,
  parameter int SZ_MIN = 2,
  parameter int SZ_MAX = 14
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  soft_rst_i,
  input logic                  push_i,
  input logic [SEL_W-1:0]      push_sel_i,
  input logic                  pop_i,
  input logic [SEL_W-1:0]      pop_sel_i,
  input logic [NF-1:0][CW-1:0] count_o,
  input logic [NF-1:0]         empty_o,
  input logic [NF-1:0]         full_o,
  input logic                  pop_valid_o,
  input logic                  tx_err_o,
  input logic                  rx_err_o,
  input logic [SZ_W-1:0]       cur_size_o
);
  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o[push_sel_i] && !soft_rst_i && !(pop_i && pop_sel_i == push_sel_i))
    |=> count_o[$past(push_sel_i)] == $past(count_o[push_sel_i]));

  assert_tx_err_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_err_o && !soft_rst_i) |=> tx_err_o);

  assert_rx_err_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_err_o && !soft_rst_i) |=> rx_err_o);

  assert_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o[pop_sel_i] && !soft_rst_i) |=> !pop_valid_o);

  assert_pop_latency_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !empty_o[pop_sel_i] && !soft_rst_i) |=> pop_valid_o);

  assert_soft_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (count_o == '0) && !tx_err_o && !rx_err_o);

  assert_size_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_size_o >= SZ_W'(SZ_MIN)) && (cur_size_o <= SZ_W'(SZ_MAX)));

  assert_size_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !soft_rst_i |=> $stable(cur_size_o));
endmodule

bind fifo_part_buf fifo_part_chk #(
  .CW(CW), .SZ_W(SZ_W), .SZ_MIN(SZ_MIN), .SZ_MAX(SZ_MAX)
) u_chk (
  .clk_i, .rst_ni, .soft_rst_i, .push_i, .push_sel_i, .pop_i, .pop_sel_i,
  .count_o, .empty_o, .full_o, .pop_valid_o, .tx_err_o, .rx_err_o, .cur_size_o
);

// File: tb/fifo_part_buf_tb.sv
`timescale 1ns/1ps
module fifo_part_buf_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0;
  logic [3:0] cfg_size = 4'd6;
  logic push = 1'b0, pop = 1'b0;
  logic [1:0] push_sel = '0, pop_sel = '0;
  logic [31:0] push_data = '0;
  logic [31:0] pop_data;
  logic pop_valid;
  logic [3:0][12:0] count;
  logic [3:0] full, empty;
  logic tx_err, rx_err;
  logic [3:0] cur_size;

  always #2.5 clk = ~clk;

  fifo_part_buf dut_i (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .cfg_size_i(cfg_size),
    .push_i(push), .push_sel_i(push_sel), .push_data_i(push_data),
    .pop_i(pop), .pop_sel_i(pop_sel), .pop_data_o(pop_data), .pop_valid_o(pop_valid),
    .count_o(count), .full_o(full), .empty_o(empty),
    .tx_err_o(tx_err), .rx_err_o(rx_err), .cur_size_o(cur_size)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] q [4][$];
  int m_sz = 6;
  bit m_txe = 0, m_rxe = 0, m_rv = 0;
  logic [31:0] m_rd = '0;

  function automatic int lim_of(int f, int s);
    int tx, rx, rxs;
    tx = s * 256; rx = 4096 - tx; rxs = rx / 16;
    case (f)
      0: return tx - 128;
      1: return 128;
      2: return rx - rxs - 4;
      default: return rxs;
    endcase
  endfunction

  // reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_sz = 6; m_txe = 0; m_rxe = 0; m_rv = 0;
      for (int i = 0; i < 4; i++) q[i].delete();
    end else begin
      m_rv = 0;
      if (soft_rst) begin
        if (cfg_size >= 2 && cfg_size <= 14) m_sz = cfg_size;
        m_txe = 0; m_rxe = 0;
        for (int i = 0; i < 4; i++) q[i].delete();
      end else begin
        bit pf, pe;
        pf = q[push_sel].size() >= lim_of(push_sel, m_sz);
        pe = q[pop_sel].size() == 0;
        if (pop) begin
          if (pe) begin if (pop_sel < 2) m_txe = 1; else m_rxe = 1; end
          else begin m_rd = q[pop_sel].pop_front(); m_rv = 1; end
        end
        if (push) begin
          if (pf) begin if (push_sel < 2) m_txe = 1; else m_rxe = 1; end
          else q[push_sel].push_back(push_data);
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    for (int i = 0; i < 4; i++) begin
      check(count[i] == q[i].size(), $sformatf("R9 count fifo%0d", i), count[i], q[i].size());
      check(full[i] == (q[i].size() >= lim_of(i, m_sz)), $sformatf("R1 full fifo%0d", i), full[i], q[i].size() >= lim_of(i, m_sz));
      check(empty[i] == (q[i].size() == 0), $sformatf("R9 empty fifo%0d", i), empty[i], q[i].size() == 0);
    end
    check(tx_err == m_txe, "R3 tx_err", tx_err, m_txe);
    check(rx_err == m_rxe, "R4 rx_err", rx_err, m_rxe);
    check(cur_size == m_sz, "R6 cur_size", cur_size, m_sz);
    check(pop_valid == m_rv, "R5 pop_valid", pop_valid, m_rv);
    if (m_rv) check(pop_data == m_rd, "R5 pop_data", pop_data, m_rd);
  endtask

  task automatic step(input bit pu, input int ps, input logic [31:0] d,
                      input bit po, input int os, input bit sr, input int cs);
    push = pu; push_sel = 2'(ps); push_data = d;
    pop = po; pop_sel = 2'(os); soft_rst = sr; cfg_size = 4'(cs);
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, cur_size); endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: default state after reset
    check(cur_size == 6 && empty == 4'hF && !tx_err && !rx_err, "R10 reset state",
          {cur_size, empty, tx_err, rx_err}, {4'd6, 4'hF, 2'b00});
    idle();

    // R3: overflow the transmit status queue
    for (int i = 0; i < 130; i++) step(1, 1, 32'h1000 + i, 0, 0, 0, 6);
    check(count[1] == 128 && tx_err && !rx_err, "R3 tx status overflow", count[1], 128);
    // R5: order out of the transmit status queue, then R4 underflow
    for (int i = 0; i < 129; i++) step(0, 0, 0, 1, 1, 0, 6);
    check(empty[1] && !pop_valid, "R4 pop empty dropped", pop_valid, 0);
    // R6: soft reset clears errors
    step(1, 0, 32'hdead, 0, 0, 1, 6);
    check(!tx_err && count == '0, "R6 soft reset clears", tx_err, 0);

    // R2: receive data early full at 2396 for size 6
    for (int i = 0; i < 2397; i++) step(1, 2, i, 0, 0, 0, 6);
    check(count[2] == 2396 && full[2] && rx_err, "R2 rx data early full", count[2], 2396);

    // R8: size change without soft reset
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 14);
    check(cur_size == 6 && count[2] == 2396, "R8 size held", cur_size, 6);
    // R7: reserved values ignored
    step(0, 0, 0, 0, 0, 1, 15);
    check(cur_size == 6, "R7 reserved 15", cur_size, 6);
    step(0, 0, 0, 0, 0, 1, 1);
    check(cur_size == 6, "R7 reserved 1", cur_size, 6);
    step(0, 0, 0, 0, 0, 1, 0);
    check(cur_size == 6, "R7 reserved 0", cur_size, 6);

    // R1: size 14 gives receive status 32 words
    step(0, 0, 0, 0, 0, 1, 14);
    check(cur_size == 14, "R6 size loaded", cur_size, 14);
    for (int i = 0; i < 33; i++) step(1, 3, 32'h3000 + i, 0, 0, 0, 14);
    check(count[3] == 32 && full[3] && rx_err && !tx_err, "R1 rx status depth 32", count[3], 32);

    // R11: push and pop on the same FIFO
    step(1, 0, 32'haaaa, 0, 0, 0, 14);
    step(1, 0, 32'hbbbb, 1, 0, 0, 14);
    check(count[0] == 1 && pop_valid && pop_data == 32'haaaa, "R11 push+pop same", count[0], 1);

    // R9: random traffic with wraps, sizes 14 and 2
    for (int s = 0; s < 2; s++) begin
      step(0, 0, 0, 0, 0, 1, s == 0 ? 14 : 2);
      for (int i = 0; i < 5000; i++)
        step(($urandom % 10) < 6, $urandom % 4, $urandom, ($urandom % 10) < 5, $urandom % 4, 0, cur_size);
    end
    check(cur_size == 2, "R1 final size 2", cur_size, 2);
    idle();

    summary();
    $finish;
  end
endmodule